// File: doc/BRIEF.md
# PCI Configuration Access Translator

This block sits on the host side of a PCI host bridge. It exposes two windows through one valid/ready access port. The index window holds a 32-bit configuration index register. Every read or write to the data window combines that index with the low offset bits of the access and forms a type-0 style configuration address: device at bits 15:11, function at 10:8, register at 7:2, and byte at 1:0. It then issues one configuration request downstream, waits for the response, and returns read data on a one-cycle response pulse.

Three index layouts are accepted:
- **Pass-through:** when the top index bit is set, the index is used nearly as is.
- **Encoded:** when bit 0 is set, the index is already in encoded form.
- **Slot-select:** in all other cases the index is a one-hot slot select, which is turned into a binary device number by finding its lowest set bit.

Data is little-endian. Accesses of 1, 2 or 4 bytes are moved onto the matching byte lanes.

Back-pressure on the access port works as follows. An access is taken in a cycle where both `hst_valid` and `hst_ready` are high. `hst_ready` falls for the whole life of a data-window access, so only one configuration request is ever outstanding. On the downstream side, a request stays asserted and unchanged until `cfg_req_ready` is seen.

Top module: `cfg_xlate_top`

## Requirements
- R1: After reset the index register reads as zero, `hst_ready` is high, and neither `rsp_valid` nor `cfg_req_valid` is asserted.
- R2: Index-window accesses behave as follows:
  - A write stores all 32 bits of `hst_wdata`, whatever the size code or offset.
  - A read returns the stored value unchanged.
  - Neither kind ever raises `cfg_req_valid`.
- R3: When index bit 31 is set, the address is index bits 31:2 above offset bits 1:0. This layout takes priority over the bit-0 layout.
- R4: When index bit 31 is clear and bit 0 is set, the address is index bits 31:3 above offset bits 2:0.
- R5: When index bits 31 and 0 are both clear, the address is built from these fields:
  - bits 15:11: the position (11 to 30) of the lowest set bit among index bits 31:11;
  - bits 10:3: index bits 10:3;
  - bits 2:0: offset bits 2:0;
  - bits 31:16: zero.
- R6: In the R5 layout, if none of index bits 31:11 is set, address bits 31:11 are all ones.
- R7: Data-window offset bits above bit 2 have no effect on the address.
- R8: Size codes are 0 for 1 byte, 1 for 2 bytes, and 2 or 3 for 4 bytes. The size code is forwarded on `cfg_req_size`. Byte enables depend on size:
  - 1 byte: enable 1 shifted left by offset bits 1:0.
  - 2 bytes: 0011, or 1100 when offset bit 1 is set.
  - 4 bytes: 1111.

  Write data is cut to the access size and moved up to the first enabled lane.
- R9: Read data from the downstream side is shifted down from the first enabled lane and zeroed above the access size.
- R10: `hst_ready` is low from the cycle after a data-window access is taken until the cycle after its downstream response. While `cfg_req_valid` is high and `cfg_req_ready` is low, the request fields stay stable.
- R11: `rsp_valid` is a one-cycle pulse with these rules:
  - Data-window read: the cycle after `cfg_rsp_valid`.
  - Index-window read: the cycle after the read is taken.
  - Any write: no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_valid | input | 1 | Host access request |
| hst_ready | output | 1 | Access taken when high together with hst_valid |
| hst_write | input | 1 | 1 = write, 0 = read |
| hst_win | input | 1 | 0 = index window, 1 = data window |
| hst_off | input | WIN_AW | Byte offset inside the window |
| hst_size | input | 2 | Size code (0: 1 B, 1: 2 B, 2/3: 4 B) |
| hst_wdata | input | 32 | Write data, right-justified |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 32 | Read data, right-justified |
| cfg_req_valid | output | 1 | Configuration request valid |
| cfg_req_ready | input | 1 | Downstream accepts the request |
| cfg_req_write | output | 1 | Request is a write |
| cfg_req_addr | output | 32 | Translated configuration address |
| cfg_req_be | output | 4 | Byte enables |
| cfg_req_size | output | 2 | Forwarded size code |
| cfg_req_wdata | output | 32 | Lane-aligned write data |
| cfg_rsp_valid | input | 1 | Downstream completion |
| cfg_rsp_rdata | input | 32 | Downstream read data, lane-aligned |

## Verification
The bench builds the block with its default window width of 12 offset bits. With that width it can drive offsets near the top of the 4 KiB window and show that they alias onto the same address as their low three bits. The downstream responder's latency is a bench variable, set to zero and to five cycles. This brings the exact stall length and the response-pulse timing within reach. The slot-select layout is swept over every slot position from 11 to 30, and also run with no slot bit set.

// File: rtl/cfg_xlate_pkg.sv
package cfg_xlate_pkg;
  localparam int DW       = 32;
  localparam int BE_W     = DW / 8;
  localparam int SLOT_LSB = 11;
  localparam int DEV_W    = $clog2(DW);
  localparam int LOW_KEEP = 3;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } seq_st_e;

  typedef struct packed {
    logic                wr;
    logic [1:0]          size;
    logic [LOW_KEEP-1:0] off;
    logic [DW-1:0]       wdata;
  } acc_t;
endpackage

// File: rtl/cfg_addr_conv.sv
module cfg_addr_conv
  import cfg_xlate_pkg::*;
(
  input  logic [DW-1:0]       idx,
  input  logic [LOW_KEEP-1:0] off,
  output logic [DW-1:0]       addr
);
  logic [DEV_W-1:0] dev;
  logic             found;

  // lowest set slot bit wins: scan from the top so the last hit is the lowest
  always_comb begin
    dev   = '1;
    found = 1'b0;
    for (int b = DW - 1; b >= SLOT_LSB; b--) begin
      if (idx[b]) begin
        dev   = DEV_W'(b);
        found = 1'b1;
      end
    end
  end

  always_comb begin
    addr = '0;
    if (idx[DW-1]) begin
      addr = {idx[DW-1:2], off[1:0]};
    end else if (idx[0]) begin
      addr = {idx[DW-1:3], off};
    end else begin
      addr[SLOT_LSB +: DEV_W]  = dev;
      addr[SLOT_LSB-1:3]       = idx[SLOT_LSB-1:3];
      addr[2:0]                = off;
      if (!found) begin
        addr[DW-1:SLOT_LSB] = '1;
      end
    end
  end
endmodule

// File: rtl/cfg_lane_map.sv
module cfg_lane_map
  import cfg_xlate_pkg::*;
(
  input  logic [1:0]      size,
  input  logic [1:0]      off,
  input  logic [DW-1:0]   wdata_in,
  input  logic [DW-1:0]   rdata_in,
  output logic [BE_W-1:0] be,
  output logic [DW-1:0]   wdata_out,
  output logic [DW-1:0]   rdata_out
);
  logic [1:0]      lane;
  logic [BE_W-1:0] base;
  logic [DW-1:0]   keep;
  logic [4:0]      shamt;

  always_comb begin
    case (size)
      SZ_BYTE: begin lane = off;              base = 4'b0001; keep = 32'h0000_00FF; end
      SZ_HALF: begin lane = {off[1], 1'b0};   base = 4'b0011; keep = 32'h0000_FFFF; end
      default: begin lane = 2'b00;            base = 4'b1111; keep = 32'hFFFF_FFFF; end
    endcase
    shamt     = {lane, 3'b000};
    be        = base << lane;
    wdata_out = (wdata_in & keep) << shamt;
    rdata_out = (rdata_in >> shamt) & keep;
  end
endmodule

// File: rtl/cfg_xlate_top.sv
module cfg_xlate_top
  import cfg_xlate_pkg::*;
#(
  parameter int WIN_AW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hst_valid,
  output logic              hst_ready,
  input  logic              hst_write,
  input  logic              hst_win,
  input  logic [WIN_AW-1:0] hst_off,
  input  logic [1:0]        hst_size,
  input  logic [31:0]       hst_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              cfg_req_valid,
  input  logic              cfg_req_ready,
  output logic              cfg_req_write,
  output logic [31:0]       cfg_req_addr,
  output logic [3:0]        cfg_req_be,
  output logic [1:0]        cfg_req_size,
  output logic [31:0]       cfg_req_wdata,
  input  logic              cfg_rsp_valid,
  input  logic [31:0]       cfg_rsp_rdata
);
  seq_st_e       st_q;
  acc_t          acc_q;
  logic [DW-1:0] idx_q;
  logic          rsp_valid_q;
  logic [DW-1:0] rsp_data_q;
  logic [DW-1:0] lane_rdata;
  logic          take;
  logic          unused_off;

  // offset bits above the low three only select inside the 4 KiB window
  assign unused_off = ^hst_off[WIN_AW-1:LOW_KEEP];

  assign hst_ready     = (st_q == ST_IDLE);
  assign take          = hst_valid && hst_ready;
  assign cfg_req_valid = (st_q == ST_ISSUE);
  assign cfg_req_write = acc_q.wr;
  assign cfg_req_size  = acc_q.size;
  assign rsp_valid     = rsp_valid_q;
  assign rsp_rdata     = rsp_data_q;

  cfg_addr_conv u_conv (
    .idx  (idx_q),
    .off  (acc_q.off),
    .addr (cfg_req_addr)
  );

  cfg_lane_map u_lane (
    .size      (acc_q.size),
    .off       (acc_q.off[1:0]),
    .wdata_in  (acc_q.wdata),
    .rdata_in  (cfg_rsp_rdata),
    .be        (cfg_req_be),
    .wdata_out (cfg_req_wdata),
    .rdata_out (lane_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      acc_q       <= '0;
      idx_q       <= '0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (take) begin
            if (!hst_win) begin
              if (hst_write) begin
                idx_q <= hst_wdata;
              end else begin
                rsp_valid_q <= 1'b1;
                rsp_data_q  <= idx_q;
              end
            end else begin
              acc_q <= '{wr: hst_write, size: hst_size,
                         off: hst_off[LOW_KEEP-1:0], wdata: hst_wdata};
              st_q  <= ST_ISSUE;
            end
          end
        end
        ST_ISSUE: begin
          if (cfg_req_ready) st_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (cfg_rsp_valid) begin
            st_q <= ST_IDLE;
            if (!acc_q.wr) begin
              rsp_valid_q <= 1'b1;
              rsp_data_q  <= lane_rdata;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_xlate_chk.sv
module cfg_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        hst_ready,
  input logic        cfg_req_valid,
  input logic        cfg_req_ready,
  input logic [31:0] cfg_req_addr,
  input logic [3:0]  cfg_req_be,
  input logic [1:0]  cfg_req_size,
  input logic [31:0] idx
);
  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid && !cfg_req_ready |=>
      cfg_req_valid && $stable(cfg_req_addr) && $stable(cfg_req_be));

  a_r10_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid |-> !hst_ready);

  a_r8_be_count: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid |-> $countones(cfg_req_be) ==
      ((cfg_req_size == 2'd0) ? 1 : (cfg_req_size == 2'd1) ? 2 : 4));

  a_r3_direct_upper: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid && idx[31] |-> cfg_req_addr[31:2] == idx[31:2]);

  a_r6_no_slot: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid && !idx[31] && !idx[0] && (idx[31:11] == '0) |->
      &cfg_req_addr[31:11]);
endmodule

bind cfg_xlate_top cfg_xlate_chk i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .hst_ready     (hst_ready),
  .cfg_req_valid (cfg_req_valid),
  .cfg_req_ready (cfg_req_ready),
  .cfg_req_addr  (cfg_req_addr),
  .cfg_req_be    (cfg_req_be),
  .cfg_req_size  (cfg_req_size),
  .idx           (idx_q)
);

// File: tb/test_cfg_xlate_top.sv
`timescale 1ns/1ps
module test_cfg_xlate_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hst_valid = 1'b0, hst_write = 1'b0, hst_win = 1'b0;
  logic [11:0] hst_off = '0;
  logic [1:0]  hst_size = '0;
  logic [31:0] hst_wdata = '0;
  logic        hst_ready, rsp_valid;
  logic [31:0] rsp_rdata;
  logic        cfg_req_valid, cfg_req_write;
  logic        cfg_req_ready = 1'b0;
  logic [31:0] cfg_req_addr, cfg_req_wdata;
  logic [3:0]  cfg_req_be;
  logic [1:0]  cfg_req_size;
  logic        cfg_rsp_valid = 1'b0;
  logic [31:0] cfg_rsp_rdata = '0;

  int checks = 0, fails = 0;
  int ds_lat = 0, ds_cnt = 0, ds_reqs = 0;
  bit ds_busy = 0;
  logic [31:0] ds_rdata = '0, cap_addr, cap_wdata;
  logic [3:0]  cap_be;
  logic [1:0]  cap_size;
  logic        cap_wr;

  always #4 clk = ~clk;

  cfg_xlate_top #(.WIN_AW(12)) i_cfg_xlate_top (
    .clk(clk), .rst_n(rst_n), .hst_valid(hst_valid), .hst_ready(hst_ready),
    .hst_write(hst_write), .hst_win(hst_win), .hst_off(hst_off),
    .hst_size(hst_size), .hst_wdata(hst_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .cfg_req_valid(cfg_req_valid),
    .cfg_req_ready(cfg_req_ready), .cfg_req_write(cfg_req_write),
    .cfg_req_addr(cfg_req_addr), .cfg_req_be(cfg_req_be),
    .cfg_req_size(cfg_req_size), .cfg_req_wdata(cfg_req_wdata),
    .cfg_rsp_valid(cfg_rsp_valid), .cfg_rsp_rdata(cfg_rsp_rdata));

  // downstream responder: ready for one cycle, then answers after ds_lat cycles
  always @(negedge clk) begin
    cfg_rsp_valid = 1'b0;
    if (cfg_req_ready) begin
      cfg_req_ready = 1'b0; ds_busy = 1; ds_cnt = ds_lat;
    end else if (ds_busy) begin
      if (ds_cnt == 0) begin
        cfg_rsp_valid = 1'b1; cfg_rsp_rdata = ds_rdata; ds_busy = 0;
      end else ds_cnt--;
    end else if (cfg_req_valid) begin
      cfg_req_ready = 1'b1; ds_reqs++;
      cap_addr = cfg_req_addr; cap_be = cfg_req_be; cap_wr = cfg_req_write;
      cap_wdata = cfg_req_wdata; cap_size = cfg_req_size;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_addr(input logic [31:0] idx, input logic [11:0] off);
    logic [31:0] r;
    int s;
    if (idx[31]) r = (idx & ~32'h3) | {30'd0, off[1:0]};
    else if (idx[0]) r = (idx & ~32'h7) | {29'd0, off[2:0]};
    else begin
      s = -1;
      for (int b = 11; b < 32; b++) if (idx[b] && s < 0) s = b;
      r = (s < 0) ? 32'hFFFF_F800 : (32'(s) << 11);
      r = r | (idx & 32'h0000_07F8) | {29'd0, off[2:0]};
    end
    return r;
  endfunction

  task automatic host_acc(input bit win, input bit wr, input logic [11:0] off,
                          input logic [1:0] sz, input logic [31:0] wd,
                          output logic [31:0] rd, output int waits,
                          output bit busy, output bit rsp_seen);
    @(negedge clk);
    hst_valid = 1'b1; hst_win = win; hst_write = wr; hst_off = off;
    hst_size = sz; hst_wdata = wd;
    while (!hst_ready) @(negedge clk);
    @(negedge clk);
    hst_valid = 1'b0;
    waits = 0; rd = '0; rsp_seen = 0; busy = !hst_ready;
    if (!wr) begin
      while (!rsp_valid && waits < 200) begin
        @(negedge clk); waits++;
        if (!hst_ready) busy = 1;
      end
      rsp_seen = rsp_valid; rd = rsp_rdata;
    end else begin
      if (rsp_valid) rsp_seen = 1;
      while (!hst_ready && waits < 200) begin
        @(negedge clk); waits++;
        if (rsp_valid) rsp_seen = 1;
      end
      @(negedge clk);
      if (rsp_valid) rsp_seen = 1;
    end
  endtask

  task automatic set_idx(input logic [31:0] v);
    logic [31:0] rd; int w; bit b, s;
    host_acc(1'b0, 1'b1, 12'h000, 2'd2, v, rd, w, b, s);
  endtask

  task automatic t_reset;
    logic [31:0] rd; int w; bit b, s;
    chk("R1 hst_ready", {31'd0, hst_ready}, 32'd1);
    chk("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R1 cfg_req_valid", {31'd0, cfg_req_valid}, 32'd0);
    host_acc(1'b0, 1'b0, 12'h000, 2'd2, 32'h0, rd, w, b, s);
    chk("R1 index reset value", rd, 32'h0);
  endtask

  task automatic t_index_rw;
    logic [31:0] rd; int w, r0; bit b, s;
    r0 = ds_reqs;
    host_acc(1'b0, 1'b1, 12'h004, 2'd0, 32'hDEAD_BEEF, rd, w, b, s);
    chk("R2 index write no rsp", {31'd0, s}, 32'd0);
    host_acc(1'b0, 1'b0, 12'hFFC, 2'd0, 32'h0, rd, w, b, s);
    chk("R2 index readback", rd, 32'hDEAD_BEEF);
    chk("R11 index read pulse next cycle", w, 0);
    chk("R2 no downstream request", ds_reqs, r0);
  endtask

  task automatic t_direct;
    logic [31:0] rd; int w; bit b, s;
    set_idx(32'h8000_AB07);
    ds_rdata = 32'hCAFE_BABE;
    host_acc(1'b1, 1'b0, 12'h006, 2'd1, 32'h0, rd, w, b, s);
    chk("R3 direct address", cap_addr, 32'h8000_AB06);
    chk("R8 half be upper", {28'd0, cap_be}, 32'hC);
    chk("R8 size forwarded", {30'd0, cap_size}, 32'd1);
    chk("R9 half read lanes", rd, 32'h0000_CAFE);
    chk("R3 read flag", {31'd0, cap_wr}, 32'd0);
    set_idx(32'h8000_0001);
    ds_rdata = 32'h1122_3344;
    host_acc(1'b1, 1'b0, 12'h003, 2'd0, 32'h0, rd, w, b, s);
    chk("R3 priority over bit0", cap_addr, 32'h8000_0003);
    chk("R8 byte be lane3", {28'd0, cap_be}, 32'h8);
    chk("R9 byte read lane3", rd, 32'h0000_0011);
  endtask

  task automatic t_type1;
    logic [31:0] rd; int w; bit b, s;
    set_idx(32'h0012_3457);
    host_acc(1'b1, 1'b1, 12'h005, 2'd0, 32'hFFFF_FFA5, rd, w, b, s);
    chk("R4 encoded address", cap_addr, 32'h0012_3455);
    chk("R8 byte be lane1", {28'd0, cap_be}, 32'h2);
    chk("R8 write data lane1", cap_wdata, 32'h0000_A500);
    chk("R4 write flag", {31'd0, cap_wr}, 32'd1);
    chk("R11 write gives no rsp", {31'd0, s}, 32'd0);
  endtask

  task automatic t_slot;
    logic [31:0] rd, iv; int w; bit b, s;
    set_idx(32'h0010_25AE);
    ds_rdata = 32'h0BAD_F00D;
    host_acc(1'b1, 1'b0, 12'h004, 2'd2, 32'h0, rd, w, b, s);
    chk("R5 slot address", cap_addr, 32'h0000_6DAC);
    chk("R8 word be", {28'd0, cap_be}, 32'hF);
    chk("R9 word read", rd, 32'h0BAD_F00D);
    set_idx(32'h4000_0000);
    host_acc(1'b1, 1'b1, 12'h002, 2'd1, 32'h5555_1234, rd, w, b, s);
    chk("R5 slot 30 address", cap_addr, 32'h0000_F002);
    chk("R8 half write lanes", cap_wdata, 32'h1234_0000);
    for (int k = 11; k < 31; k++) begin
      iv = (32'd1 << k) | 32'h0000_0370;
      set_idx(iv);
      host_acc(1'b1, 1'b0, 12'h001, 2'd0, 32'h0, rd, w, b, s);
      chk($sformatf("R5 slot sweep %0d", k), cap_addr, ref_addr(iv, 12'h001));
    end
  endtask

  task automatic t_no_slot;
    logic [31:0] rd; int w; bit b, s;
    set_idx(32'h0000_06F0);
    host_acc(1'b1, 1'b0, 12'h001, 2'd0, 32'h0, rd, w, b, s);
    chk("R6 no slot bit", cap_addr, 32'hFFFF_FEF1);
  endtask

  task automatic t_offset;
    logic [31:0] rd; int w; bit b, s;
    set_idx(32'h0012_3457);
    host_acc(1'b1, 1'b0, 12'hFF6, 2'd0, 32'h0, rd, w, b, s);
    chk("R7 high offset ignored", cap_addr, 32'h0012_3456);
    set_idx(32'h8765_4320);
    host_acc(1'b1, 1'b0, 12'h7FD, 2'd0, 32'h0, rd, w, b, s);
    chk("R7 high offset direct", cap_addr, 32'h8765_4321);
  endtask

  task automatic t_latency;
    logic [31:0] rd; int w; bit b, s;
    set_idx(32'h0000_0801);
    ds_lat = 0; ds_rdata = 32'h0000_00AA;
    host_acc(1'b1, 1'b0, 12'h000, 2'd2, 32'h0, rd, w, b, s);
    chk("R11 pulse after response lat0", w, 3);
    chk("R10 busy during access", {31'd0, b}, 32'd1);
    ds_lat = 5;
    host_acc(1'b1, 1'b0, 12'h000, 2'd2, 32'h0, rd, w, b, s);
    chk("R11 pulse after response lat5", w, 8);
    chk("R10 busy long access", {31'd0, b}, 32'd1);
    @(negedge clk);
    chk("R11 pulse one cycle", {31'd0, rsp_valid}, 32'd0);
    chk("R10 ready after done", {31'd0, hst_ready}, 32'd1);
    ds_lat = 0;
  endtask

  task automatic report;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_index_rw();
    t_direct();
    t_type1();
    t_slot();
    t_no_slot();
    t_offset();
    t_latency();
    report();
    $finish;
  end
endmodule